// File: doc/BRIEF.md
# SDRAM Full-Page Write Burst Sequencer

This block drives the command, address and data pins of a single-data-rate SDRAM for one full-page write burst. A host posts a request holding a bank, a row, a starting column and a word count. The sequencer opens the row, waits out the row-to-column delay, then issues the write command together with the first data word. It streams one 32-bit word per clock after that, and the device advances and wraps the column inside the 256-column row by itself.

A full-page burst has no natural end, so the sequencer counts the words it has accepted. After the requested count, or as soon as the host stops offering data, it ends the burst with an explicit burst-terminate command. The row is left open. The block then times the write-recovery interval from the last data word and only after that reports that a precharge of the open bank is safe. Refresh, reads, mode programming and precharge itself belong to other logic.

Top module: `sdram_page_writer`

## Requirements
- R1: While reset is asserted, chip select and the three command lines are high, the data drivers are off, all byte masks are high, and busy, write-ready and precharge-allowed are low.
- R2: A request offered while busy is low is taken on that clock edge. In the next cycle the ACTIVE command ({RAS#,CAS#,WE#} = 0,1,1 with CS# low) is on the pins, the request bank is on the bank lines, the row is on the address lines, and busy is high.
- R3: Write-ready stays low until the cycle that is T_RCD-1 cycles after the ACTIVE cycle. The WRITE command therefore never reaches the pins earlier than T_RCD cycles after ACTIVE. Between ACTIVE and the first data word, the pins carry NOP ({RAS#,CAS#,WE#} = 1,1,1 with CS# low).
- R4: The WRITE command ({RAS#,CAS#,WE#} = 1,0,0) carries the start column in address bits 7:0, and all higher address bits, including the auto-precharge bit 10, are zero.
- R5: Each word taken with write-valid and write-ready both high is driven on the data pins in the next cycle, with the drivers enabled and all four byte masks low. The first word goes out with WRITE and every later word with NOP.
- R6: A count of 1 to 255 requests that many words, and a count of 0 requests a full page of 256. After the last word is taken, write-ready drops, and BURST TERMINATE ({RAS#,CAS#,WE#} = 1,1,0) is on the pins in the cycle after the last data word.
- R7: If write-valid is low while write-ready is high and at least one word has already gone out, the burst ends there, and BURST TERMINATE follows in the cycle after the last data word. Before the first word, a low write-valid only prolongs the wait, with NOPs on the pins.
- R8: Busy stays high until the cycle that is T_WR cycles after the last data word. In that cycle busy is low and precharge-allowed rises. Precharge-allowed stays high until the next request is taken.
- R9: A request offered while busy is high is ignored: no command other than the burst's own appears on the pins.
- R10: The bank lines keep the request bank from ACTIVE through the data phase and BURST TERMINATE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Burst request offered |
| req_bank | input | 2 | Bank of the burst |
| req_row | input | 12 | Row to open |
| req_col | input | 8 | Start column |
| req_count | input | 9 | Word count, 1 to 255, or 0 for 256 |
| busy | output | 1 | Request in progress, including write recovery |
| precharge_ok | output | 1 | Write recovery done, row still open |
| wr_valid | input | 1 | Host data word valid |
| wr_data | input | 32 | Host data word |
| wr_ready | output | 1 | Sequencer takes a word this cycle |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_ba | output | 2 | SDRAM bank address |
| sd_addr | output | 12 | SDRAM address bus |
| sd_dq | output | 32 | SDRAM write data |
| sd_dq_oe | output | 1 | Data driver enable |
| sd_dqm | output | 4 | Byte masks, active high |

## Verification
Every pin output is registered. ACTIVE appears one cycle after the request edge, each data word one cycle after its handshake edge, BURST TERMINATE one cycle after the last data word, and precharge-allowed T_WR cycles after that last word. Write-ready and busy follow the internal state within the same cycle. The bench changes inputs and samples outputs on the falling clock edge. It keeps its own cycle index from the ACTIVE cycle and its own count of words sent, and it compares each pin in the exact cycle these latencies predict. Random bursts vary the bank, row, column, length, stall before the first word and early stop, and the directed cases cover a single word, a full page starting mid-row, 255 words, and requests held high while busy.

// File: rtl/sdpw_pkg.sv
package sdpw_pkg;

    // Command code on {RAS#, CAS#, WE#}, chip select held low while active
    typedef enum logic [2:0] {
        CMD_NOP = 3'b111,
        CMD_ACT = 3'b011,
        CMD_WR  = 3'b100,
        CMD_BST = 3'b110
    } sd_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OPEN,
        ST_TERM,
        ST_RECOV
    } seq_st_e;

endpackage

// File: rtl/sdpw_delay.sv
// Loadable down counter; expired is high while the count rests at zero.
module sdpw_delay #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdpw_words.sv
// Remaining-word counter for one burst; a zero load means a whole page.
module sdpw_words #(
    parameter int PAGE  = 256,
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);

    logic [CNT_W-1:0] rem_d, rem_q;

    always_comb begin
        rem_d = rem_q;
        if (load) begin
            rem_d = (load_val == '0) ? CNT_W'(PAGE) : load_val;
        end else if (dec) begin
            rem_d = rem_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else begin
            rem_q <= rem_d;
        end
    end

    assign last = (rem_q == CNT_W'(1));

    // R6: no word is taken once the requested count is used up
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (rem_q != '0));

endmodule

// File: rtl/sdram_page_writer.sv
module sdram_page_writer
    import sdpw_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int T_RCD  = 3,
    parameter int T_WR   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [BANK_W-1:0]   req_bank,
    input  logic [ROW_W-1:0]    req_row,
    input  logic [COL_W-1:0]    req_col,
    input  logic [COL_W:0]      req_count,
    output logic                busy,
    output logic                precharge_ok,
    input  logic                wr_valid,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                wr_ready,
    output logic                sd_cs_n,
    output logic                sd_ras_n,
    output logic                sd_cas_n,
    output logic                sd_we_n,
    output logic [BANK_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0]   sd_addr,
    output logic [DATA_W-1:0]   sd_dq,
    output logic                sd_dq_oe,
    output logic [DATA_W/8-1:0] sd_dqm
);

    localparam int PAGE    = 1 << COL_W;
    localparam int CNT_W   = COL_W + 1;
    localparam int MASK_W  = DATA_W / 8;
    localparam int DLY_MAX = (T_RCD > T_WR) ? T_RCD : T_WR;
    localparam int DLY_W   = $clog2(DLY_MAX + 1);
    localparam int GAP_W   = $clog2(T_RCD + 1);

    typedef struct packed {
        seq_st_e             st;
        logic                started;
        logic                opened;
        logic                cs_n;
        sd_cmd_e             cmd;
        logic [BANK_W-1:0]   ba;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   dq;
        logic                dq_oe;
        logic [MASK_W-1:0]   dqm;
        logic [COL_W-1:0]    col;
    } seq_t;

    localparam seq_t S_RESET = '{
        st:      ST_IDLE,
        started: 1'b0,
        opened:  1'b0,
        cs_n:    1'b1,
        cmd:     CMD_NOP,
        ba:      '0,
        addr:    '0,
        dq:      '0,
        dq_oe:   1'b0,
        dqm:     '1,
        col:     '0
    };

    seq_t s_d, s_q;

    logic             dly_load;
    logic [DLY_W-1:0] dly_val;
    logic             dly_expired;
    logic             cnt_load;
    logic             cnt_dec;
    logic             cnt_last;
    logic             take;

    // Row-to-column wait and write recovery share one counter; they never overlap.
    sdpw_delay #(
        .W (DLY_W)
    ) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dly_load),
        .load_val (dly_val),
        .expired  (dly_expired)
    );

    sdpw_words #(
        .PAGE  (PAGE),
        .CNT_W (CNT_W)
    ) u_words (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (req_count),
        .dec      (cnt_dec),
        .last     (cnt_last)
    );

    assign busy         = (s_q.st != ST_IDLE) && !((s_q.st == ST_RECOV) && dly_expired);
    assign wr_ready     = (s_q.st == ST_OPEN) && dly_expired;
    assign precharge_ok = s_q.opened && !busy;
    assign take         = wr_ready && wr_valid;

    always_comb begin
        s_d       = s_q;
        s_d.cs_n  = 1'b0;
        s_d.cmd   = CMD_NOP;
        s_d.addr  = '0;
        s_d.dq_oe = 1'b0;
        s_d.dqm   = '1;
        dly_load  = 1'b0;
        dly_val   = '0;
        cnt_load  = 1'b0;
        cnt_dec   = 1'b0;

        if (!busy) begin
            if (req_valid) begin
                s_d.st      = ST_OPEN;
                s_d.cmd     = CMD_ACT;
                s_d.ba      = req_bank;
                s_d.addr    = ADDR_W'(req_row);
                s_d.col     = req_col;
                s_d.started = 1'b0;
                s_d.opened  = 1'b1;
                dly_load    = 1'b1;
                dly_val     = DLY_W'(T_RCD - 1);
                cnt_load    = 1'b1;
            end else begin
                s_d.st = ST_IDLE;
            end
        end else begin
            case (s_q.st)
                ST_OPEN: begin
                    if (take) begin
                        s_d.dq      = wr_data;
                        s_d.dq_oe   = 1'b1;
                        s_d.dqm     = '0;
                        s_d.started = 1'b1;
                        cnt_dec     = 1'b1;
                        if (!s_q.started) begin
                            s_d.cmd  = CMD_WR;
                            s_d.addr = ADDR_W'(s_q.col);
                        end
                        if (cnt_last) begin
                            s_d.st = ST_TERM;
                        end
                    end else if (wr_ready && s_q.started) begin
                        s_d.cmd  = CMD_BST;
                        s_d.st   = ST_RECOV;
                        dly_load = 1'b1;
                        dly_val  = DLY_W'(T_WR - 1);
                    end
                end
                ST_TERM: begin
                    s_d.cmd  = CMD_BST;
                    s_d.st   = ST_RECOV;
                    dly_load = 1'b1;
                    dly_val  = DLY_W'(T_WR - 1);
                end
                default: begin
                    s_d.st = s_q.st;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= S_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign sd_cs_n  = s_q.cs_n;
    assign sd_ras_n = s_q.cmd[2];
    assign sd_cas_n = s_q.cmd[1];
    assign sd_we_n  = s_q.cmd[0];
    assign sd_ba    = s_q.ba;
    assign sd_addr  = s_q.addr;
    assign sd_dq    = s_q.dq;
    assign sd_dq_oe = s_q.dq_oe;
    assign sd_dqm   = s_q.dqm;

    // Cycles since ACTIVE reached the pins, saturating at T_RCD
    logic [GAP_W-1:0] gap_d, gap_q;

    always_comb begin
        gap_d = gap_q;
        if (s_q.cmd == CMD_ACT) begin
            gap_d = GAP_W'(1);
        end else if (gap_q < GAP_W'(T_RCD)) begin
            gap_d = gap_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= GAP_W'(T_RCD);
        end else begin
            gap_q <= gap_d;
        end
    end

    // R3: row-to-column delay honoured on the pins
    a_r3_rcd_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cmd == CMD_WR) |-> (gap_q >= GAP_W'(T_RCD)));

    // R4: no auto-precharge, upper address bits clear on WRITE
    a_r4_no_auto_pre: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cmd == CMD_WR) |-> (sd_addr[ADDR_W-1:COL_W] == '0));

    // R5: every driven word writes all bytes
    a_r5_bytes_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> (sd_dqm == '0));

    // R6: data phase always closes with BURST TERMINATE
    a_r6_term_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_dq_oe) |-> (s_q.cmd == CMD_BST));

    // R10: bank lines unchanged across WRITE and BURST TERMINATE
    a_r10_bank_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.cmd == CMD_WR) || (s_q.cmd == CMD_BST)) |-> $stable(sd_ba));

endmodule

// File: tb/test_sdram_page_writer.sv
module test_sdram_page_writer;

    localparam int T_RCD = 3;
    localparam int T_WR  = 2;
    localparam int PAGE  = 256;

    localparam logic [2:0] C_NOP = 3'b111;
    localparam logic [2:0] C_ACT = 3'b011;
    localparam logic [2:0] C_WR  = 3'b100;
    localparam logic [2:0] C_BST = 3'b110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [11:0] req_row = '0;
    logic [7:0]  req_col = '0;
    logic [8:0]  req_count = '0;
    logic        busy;
    logic        precharge_ok;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_ready;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;
    logic [31:0] sd_dq;
    logic        sd_dq_oe;
    logic [3:0]  sd_dqm;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sdram_page_writer i_sdram_page_writer (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_bank     (req_bank),
        .req_row      (req_row),
        .req_col      (req_col),
        .req_count    (req_count),
        .busy         (busy),
        .precharge_ok (precharge_ok),
        .wr_valid     (wr_valid),
        .wr_data      (wr_data),
        .wr_ready     (wr_ready),
        .sd_cs_n      (sd_cs_n),
        .sd_ras_n     (sd_ras_n),
        .sd_cas_n     (sd_cas_n),
        .sd_we_n      (sd_we_n),
        .sd_ba        (sd_ba),
        .sd_addr      (sd_addr),
        .sd_dq        (sd_dq),
        .sd_dq_oe     (sd_dq_oe),
        .sd_dqm       (sd_dqm)
    );

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [2:0] cmd_now();
        return {sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    function automatic int words_of(input logic [8:0] cnt);
        return (cnt == 9'd0) ? PAGE : int'(cnt);
    endfunction

    // One burst, entered and left on a falling edge with the block idle
    task automatic run_burst(input logic [1:0] bank, input logic [11:0] row,
                             input logic [7:0] col, input logic [8:0] cnt,
                             input int pre_stall, input int stop_after, input bit nag);
        int          n = words_of(cnt);
        int          nsend = (stop_after <= 0 || stop_after > n) ? n : stop_after;
        int          sent = 0;
        int          stall = pre_stall;
        int          k = 0;
        bit          prev_acc = 1'b0;
        bit          acc;
        bit          exp_ready;
        logic [31:0] prev_w = '0;
        string       rq_end = (nsend == n) ? "R6" : "R7";

        req_valid = 1'b1;
        req_bank  = bank;
        req_row   = row;
        req_col   = col;
        req_count = cnt;
        @(negedge clk);
        req_valid = nag;  // R9: a held request must be ignored while busy
        chk("R2", "command ACTIVE", 32'(cmd_now()), 32'(C_ACT));
        chk("R2", "chip select", 32'(sd_cs_n), 32'd0);
        chk("R2", "bank", 32'(sd_ba), 32'(bank));
        chk("R2", "row address", 32'(sd_addr), 32'(row));
        chk("R2", "busy", 32'(busy), 32'd1);

        forever begin
            if (prev_acc) begin
                chk("R5", "data enable", 32'(sd_dq_oe), 32'd1);
                chk("R5", "data word", sd_dq, prev_w);
                chk("R5", "byte masks", 32'(sd_dqm), 32'd0);
                chk("R5", "data command", 32'(cmd_now()), 32'((sent == 1) ? C_WR : C_NOP));
                if (sent == 1) begin
                    chk("R4", "write column", 32'(sd_addr), 32'(col));
                end
                chk("R10", "bank held", 32'(sd_ba), 32'(bank));
            end else if (k > 0) begin
                chk("R7", "wait command NOP", 32'(cmd_now()), 32'(C_NOP));
                chk("R7", "no data while waiting", 32'(sd_dq_oe), 32'd0);
            end
            exp_ready = (k >= T_RCD - 1) && (sent < n);
            chk("R3", "write ready", 32'(wr_ready), 32'(exp_ready));
            chk("R9", "busy during burst", 32'(busy), 32'd1);
            if (sent == nsend) begin
                wr_valid = 1'b0;
                break;
            end
            acc = 1'b0;
            if (exp_ready) begin
                if (stall > 0) begin
                    stall--;
                    wr_valid = 1'b0;
                end else begin
                    wr_valid = 1'b1;
                    wr_data  = $urandom;
                    acc      = 1'b1;
                end
            end else begin
                wr_valid = 1'b0;
            end
            if (acc) begin
                prev_w = wr_data;
                sent++;
            end
            prev_acc = acc;
            k++;
            @(negedge clk);
        end
        req_valid = 1'b0;

        @(negedge clk);
        chk(rq_end, "burst terminate", 32'(cmd_now()), 32'(C_BST));
        chk(rq_end, "drivers off", 32'(sd_dq_oe), 32'd0);
        chk("R10", "bank at terminate", 32'(sd_ba), 32'(bank));
        for (int off = 1; off <= T_WR; off++) begin
            if (off > 1) begin
                @(negedge clk);
                chk("R8", "NOP in recovery", 32'(cmd_now()), 32'(C_NOP));
            end
            chk("R8", "busy in recovery", 32'(busy), 32'(off < T_WR));
            chk("R8", "precharge allowed", 32'(precharge_ok), 32'(off >= T_WR));
        end
        @(negedge clk);
        chk("R8", "precharge allowed held", 32'(precharge_ok), 32'd1);
        chk("R8", "idle after recovery", 32'(busy), 32'd0);
        chk("R3", "ready low when idle", 32'(wr_ready), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1", "chip select in reset", 32'(sd_cs_n), 32'd1);
        chk("R1", "command in reset", 32'(cmd_now()), 32'(C_NOP));
        chk("R1", "drivers in reset", 32'(sd_dq_oe), 32'd0);
        chk("R1", "masks in reset", 32'(sd_dqm), 32'hf);
        chk("R1", "busy in reset", 32'(busy), 32'd0);
        chk("R1", "ready in reset", 32'(wr_ready), 32'd0);
        chk("R1", "precharge flag in reset", 32'(precharge_ok), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "precharge flag before first burst", 32'(precharge_ok), 32'd0);
        chk("R2", "idle NOP", 32'(cmd_now()), 32'(C_NOP));

        run_burst(2'd1, 12'h123, 8'h10, 9'd1,   0, 0, 1'b0);
        run_burst(2'd2, 12'h7a5, 8'h80, 9'd0,   0, 0, 1'b0);
        run_burst(2'd3, 12'hfff, 8'hff, 9'd255, 5, 0, 1'b1);
        run_burst(2'd0, 12'h001, 8'h05, 9'd40,  0, 1, 1'b0);
        run_burst(2'd1, 12'h3c3, 8'hf0, 9'd20,  2, 7, 1'b1);

        for (int i = 0; i < 12; i++) begin
            logic [8:0] c;
            int         n;
            int         stop;
            c    = (($urandom % 4) == 0) ? 9'd0 : 9'(1 + ($urandom % 255));
            n    = words_of(c);
            stop = (($urandom % 3) == 0) ? int'(1 + ($urandom % n)) : 0;
            run_burst(2'($urandom), 12'($urandom), 8'($urandom), c,
                      int'($urandom % 4), stop, 1'($urandom));
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule